// File: doc/BRIEF.md
# TLB Array Write Port

This block sits on the privileged control-space write path of a processor core. It holds the entries of a small instruction TLB and a larger unified TLB, and it applies control-space writes to them. The top byte of each write address selects a target region. Three regions change TLB state: the instruction-TLB tag region, the instruction-TLB data region and the unified-TLB tag region. Every other region is accepted and discarded. Cache arrays and store queues live elsewhere.

A write to the unified-TLB tag region with the associative flag set does not address one entry. Instead, the written word acts as a search key. The block compares its page number and address-space identifier against every valid entry in both TLBs in parallel. Each entry that hits gets its valid and dirty flags reloaded from the word, and its tag is left alone. All changes from one write land together on the next clock edge.

The translation path observes the entries through two combinational read ports. The array write-enable vectors are also brought out, so neighbouring logic can see which entries the current write touches.

Top module: `tlbw_port`

## Requirements
- R1: After reset, every entry of both TLBs is invalid and clean, and every tag word and instruction data word reads as zero.
- R2: A write with address bits [31:24] = 0xF2 targets instruction entry address[9:8]. Its tag becomes the data word with bits [9:8] cleared (AND 0xFFFFFCFF), and its valid flag becomes data bit 8. The entry's dirty flag and data word are kept.
- R3: A write with address bits [31:24] = 0xF3 and address bit 23 clear stores the whole data word into the data word of instruction entry address[9:8], and changes nothing else. With address bit 23 set, the write changes nothing.
- R4: A write with address bits [31:24] = 0xF6 and address bit 7 clear targets unified entry address[13:8]. Its tag becomes the data word AND 0xFFFFFCFF, its valid flag becomes data bit 8 and its dirty flag becomes data bit 9.
- R5: A write with address bits [31:24] = 0xF6 and address bit 7 set is associative. Every valid entry of either TLB whose key matches the data word (R6) gets valid = data bit 8 and dirty = data bit 9. Tags and instruction data words are kept, and entries that do not match are unchanged.
- R6: The key holds the page number in data bits [31:10] and the address-space identifier in bits [7:0]. Unified entries compare tag bits [31:10] and [7:0]. An instruction entry takes a size code from its data word bits [5:4] (0: 1 KB, 1: 4 KB, 2: 64 KB, 3: 1 MB) and compares tag bits from bit 10, 12, 16 or 20 upward. When its data word bit 1 is set, the identifier comparison is skipped.
- R7: Writes to any other region (for example 0xE0 to 0xE3, 0xF0, 0xF1, 0xF4, 0xF5), and cycles with the write strobe low, raise no write enable and change no entry.
- R8: During a write cycle, `ut_we`/`it_we` are high for exactly the entries the write changes. The new contents appear on the read ports after the next rising clock edge.
- R9: The read ports show the entry chosen by `ut_sel`/`it_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 32 | Control-space write address |
| wr_data | input | 32 | Write data word |
| ut_we | output | UT_N (64) | Unified entry write enables for this cycle |
| it_we | output | IT_N (4) | Instruction entry write enables for this cycle |
| ut_sel | input | log2(UT_N) (6) | Unified read port entry select |
| ut_tag | output | 32 | Selected unified tag |
| ut_valid | output | 1 | Selected unified valid flag |
| ut_dirty | output | 1 | Selected unified dirty flag |
| it_sel | input | log2(IT_N) (2) | Instruction read port entry select |
| it_tag | output | 32 | Selected instruction tag |
| it_data | output | 32 | Selected instruction data word |
| it_valid | output | 1 | Selected instruction valid flag |
| it_dirty | output | 1 | Selected instruction dirty flag |

## Verification
The assertions assume that `wr_addr` and `wr_data` hold known values whenever `wr_en` is high. They also assume that a direct unified write names an index below UT_N. With the default power-of-two depth this holds by width alone. The stimulus changes the inputs only on falling edges, never leaves them unknown, and drops the strobe between writes, so each write is judged against a settled array. Associative keys are taken from tags the bench itself placed. Some keys are perturbed in the low page bits or in the identifier, so the size and sharing rules decide which entries hit.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;

    localparam logic [7:0]  RG_ITAG  = 8'hF2;
    localparam logic [7:0]  RG_IDATA = 8'hF3;
    localparam logic [7:0]  RG_UTAG  = 8'hF6;
    localparam logic [31:0] TAG_KEEP = 32'hFFFF_FCFF;
    localparam int          V_BIT    = 8;
    localparam int          D_BIT    = 9;
    localparam int          ASSOC_BIT = 7;
    localparam int          BANK_BIT  = 23;
    localparam int          IDX_LSB   = 8;

    typedef struct packed {
        logic it_tag;
        logic it_data;
        logic ut_direct;
        logic ut_assoc;
    } op_t;

    // Compare mask over the page-number bits for a page size code
    function automatic logic [31:0] page_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    page_mask = 32'hFFFF_FC00;
            2'd1:    page_mask = 32'hFFFF_F000;
            2'd2:    page_mask = 32'hFFFF_0000;
            default: page_mask = 32'hFFF0_0000;
        endcase
    endfunction

    function automatic logic key_hit(input logic [31:0] tag, input logic vld,
                                     input logic [1:0] sz, input logic shared,
                                     input logic [31:0] key);
        logic page_eq;
        logic id_eq;
        page_eq = (((tag ^ key) & page_mask(sz)) == 32'h0);
        id_eq   = shared || (tag[7:0] == key[7:0]);
        key_hit = vld && page_eq && id_eq;
    endfunction

endpackage

// File: rtl/tlbw_decode.sv
module tlbw_decode
    import tlbw_pkg::*;
(
    input  logic        wr_en,
    input  logic [31:0] wr_addr,
    output op_t         op
);
    logic [7:0] region;

    always_comb begin
        region       = wr_addr[31:24];
        op.it_tag    = wr_en && (region == RG_ITAG);
        op.it_data   = wr_en && (region == RG_IDATA) && !wr_addr[BANK_BIT];
        op.ut_direct = wr_en && (region == RG_UTAG) && !wr_addr[ASSOC_BIT];
        op.ut_assoc  = wr_en && (region == RG_UTAG) &&  wr_addr[ASSOC_BIT];
    end
endmodule

// File: rtl/tlbw_onehot.sv
module tlbw_onehot #(
    parameter int N = 4,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] vec
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign vec[i] = en && (idx == W'(i));
    end
endmodule

// File: rtl/tlbw_match.sv
module tlbw_match
    import tlbw_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0][31:0] tags,
    input  logic [N-1:0]       vld,
    input  logic [N-1:0][1:0]  sz,
    input  logic [N-1:0]       shared,
    input  logic [31:0]        key,
    output logic [N-1:0]       hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = key_hit(tags[i], vld[i], sz[i], shared[i], key);
    end
endmodule

// File: rtl/tlbw_port.sv
module tlbw_port
    import tlbw_pkg::*;
#(
    parameter int UT_N = 64,
    parameter int IT_N = 4,
    localparam int UT_W = (UT_N > 1) ? $clog2(UT_N) : 1,
    localparam int IT_W = (IT_N > 1) ? $clog2(IT_N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [31:0]     wr_addr,
    input  logic [31:0]     wr_data,
    output logic [UT_N-1:0] ut_we,
    output logic [IT_N-1:0] it_we,
    input  logic [UT_W-1:0] ut_sel,
    output logic [31:0]     ut_tag,
    output logic            ut_valid,
    output logic            ut_dirty,
    input  logic [IT_W-1:0] it_sel,
    output logic [31:0]     it_tag,
    output logic [31:0]     it_data,
    output logic            it_valid,
    output logic            it_dirty
);
    typedef struct packed {
        logic [UT_N-1:0][31:0] ut_tag;
        logic [UT_N-1:0]       ut_v;
        logic [UT_N-1:0]       ut_d;
        logic [IT_N-1:0][31:0] it_tag;
        logic [IT_N-1:0][31:0] it_data;
        logic [IT_N-1:0]       it_v;
        logic [IT_N-1:0]       it_d;
    } st_t;

    st_t st_d, st_q;
    op_t op;

    logic [UT_N-1:0]       ut_idx_vec;
    logic [IT_N-1:0]       it_idx_vec;
    logic [UT_N-1:0]       ut_hit;
    logic [IT_N-1:0]       it_hit;
    logic [IT_N-1:0][1:0]  it_sz;
    logic [IT_N-1:0]       it_sh;

    // Region decode
    tlbw_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .op      (op)
    );

    // Indexed targets
    tlbw_onehot #(.N(UT_N), .W(UT_W)) u_ut_idx (
        .en  (op.ut_direct),
        .idx (wr_addr[IDX_LSB +: UT_W]),
        .vec (ut_idx_vec)
    );

    tlbw_onehot #(.N(IT_N), .W(IT_W)) u_it_idx (
        .en  (op.it_tag || op.it_data),
        .idx (wr_addr[IDX_LSB +: IT_W]),
        .vec (it_idx_vec)
    );

    // Per-entry page size and sharing for instruction entries
    for (genvar j = 0; j < IT_N; j++) begin : g_it_attr
        assign it_sz[j] = st_q.it_data[j][5:4];
        assign it_sh[j] = st_q.it_data[j][1];
    end

    // Associative search across both arrays
    tlbw_match #(.N(UT_N)) u_ut_match (
        .tags   (st_q.ut_tag),
        .vld    (st_q.ut_v),
        .sz     ('0),
        .shared ('0),
        .key    (wr_data),
        .hit    (ut_hit)
    );

    tlbw_match #(.N(IT_N)) u_it_match (
        .tags   (st_q.it_tag),
        .vld    (st_q.it_v),
        .sz     (it_sz),
        .shared (it_sh),
        .key    (wr_data),
        .hit    (it_hit)
    );

    // Write enables
    always_comb begin
        ut_we = ut_idx_vec | (ut_hit & {UT_N{op.ut_assoc}});
        it_we = it_idx_vec | (it_hit & {IT_N{op.ut_assoc}});
    end

    // Next state
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < UT_N; i++) begin
            if (ut_we[i]) begin
                st_d.ut_v[i] = wr_data[V_BIT];
                st_d.ut_d[i] = wr_data[D_BIT];
                if (op.ut_direct) begin
                    st_d.ut_tag[i] = wr_data & TAG_KEEP;
                end
            end
        end
        for (int j = 0; j < IT_N; j++) begin
            if (it_we[j]) begin
                if (op.it_tag) begin
                    st_d.it_tag[j] = wr_data & TAG_KEEP;
                    st_d.it_v[j]   = wr_data[V_BIT];
                end else if (op.it_data) begin
                    st_d.it_data[j] = wr_data;
                end else begin
                    st_d.it_v[j] = wr_data[V_BIT];
                    st_d.it_d[j] = wr_data[D_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read ports
    always_comb begin
        ut_tag   = st_q.ut_tag[ut_sel];
        ut_valid = st_q.ut_v[ut_sel];
        ut_dirty = st_q.ut_d[ut_sel];
        it_tag   = st_q.it_tag[it_sel];
        it_data  = st_q.it_data[it_sel];
        it_valid = st_q.it_v[it_sel];
        it_dirty = st_q.it_d[it_sel];
    end

    // Assertions
    a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        op.ut_direct |-> ($onehot0(ut_we) && (it_we == '0)));

    a_r2_single_it_target: assert property (@(posedge clk) disable iff (!rst_n)
        (op.it_tag || op.it_data) |-> ($onehot(it_we) && (ut_we == '0)));

    a_r3_bank_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[31:24] == RG_IDATA && wr_addr[BANK_BIT])
            |-> ((ut_we == '0) && (it_we == '0)));

    a_r5_tags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        op.ut_assoc |=> ($stable(st_q.ut_tag) && $stable(st_q.it_tag)
                         && $stable(st_q.it_data)));

    a_r5_valid_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        op.ut_assoc |=> ((st_q.ut_v & $past(ut_we))
                         == ({UT_N{$past(wr_data[V_BIT])}} & $past(ut_we))));

    a_r5_dirty_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        op.ut_assoc |=> ((st_q.it_d & $past(it_we))
                         == ({IT_N{$past(wr_data[D_BIT])}} & $past(it_we))));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

    a_r8_untargeted_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((((st_q.ut_v ^ $past(st_q.ut_v)) | (st_q.ut_d ^ $past(st_q.ut_d)))
                   & ~$past(ut_we)) == '0));

endmodule

// File: tb/tb_tlbw_port.sv
module tb_tlbw_port;
    localparam int CLK_PERIOD = 10;
    localparam int UN = 64;
    localparam int IN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [UN-1:0] ut_we;
    logic [IN-1:0] it_we;
    logic [5:0]    ut_sel = '0;
    logic [31:0]   ut_tag;
    logic          ut_valid;
    logic          ut_dirty;
    logic [1:0]    it_sel = '0;
    logic [31:0]   it_tag;
    logic [31:0]   it_data;
    logic          it_valid;
    logic          it_dirty;

    int checks = 0;
    int errors = 0;
    int dual_hits = 0;
    bit done = 1'b0;

    logic [31:0] m_ut_tag [UN];
    bit          m_ut_v   [UN];
    bit          m_ut_d   [UN];
    logic [31:0] m_it_tag [IN];
    logic [31:0] m_it_dat [IN];
    bit          m_it_v   [IN];
    bit          m_it_d   [IN];

    tlbw_port dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ut_we(ut_we), .it_we(it_we), .ut_sel(ut_sel), .ut_tag(ut_tag),
        .ut_valid(ut_valid), .ut_dirty(ut_dirty), .it_sel(it_sel), .it_tag(it_tag),
        .it_data(it_data), .it_valid(it_valid), .it_dirty(it_dirty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Key comparison per R6, by shifting away the offset bits
    function automatic bit bhit(input logic [31:0] t, input bit v, input logic [1:0] sz,
                                input bit sh, input logic [31:0] k);
        int s;
        s = (sz == 2'd0) ? 10 : (sz == 2'd1) ? 12 : (sz == 2'd2) ? 16 : 20;
        return v && ((t >> s) == (k >> s)) && (sh || (t[7:0] == k[7:0]));
    endfunction

    task automatic verify_all(input string rq);
        for (int i = 0; i < UN; i++) begin
            ut_sel = 6'(i);
            #1;
            chk(ut_tag === m_ut_tag[i], rq, $sformatf("ut tag %0d", i), 64'(ut_tag), 64'(m_ut_tag[i]));
            chk(ut_valid === m_ut_v[i] && ut_dirty === m_ut_d[i], rq, $sformatf("ut v/d %0d", i),
                64'({ut_valid, ut_dirty}), 64'({m_ut_v[i], m_ut_d[i]}));
        end
        for (int j = 0; j < IN; j++) begin
            it_sel = 2'(j);
            #1;
            chk(it_tag === m_it_tag[j], rq, $sformatf("it tag %0d", j), 64'(it_tag), 64'(m_it_tag[j]));
            chk(it_data === m_it_dat[j], rq, $sformatf("it data %0d", j), 64'(it_data), 64'(m_it_dat[j]));
            chk(it_valid === m_it_v[j] && it_dirty === m_it_d[j], rq, $sformatf("it v/d %0d", j),
                64'({it_valid, it_dirty}), 64'({m_it_v[j], m_it_d[j]}));
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input string rq);
        logic [UN-1:0] eu;
        logic [IN-1:0] ei;
        logic [7:0]    rg;
        eu = '0;
        ei = '0;
        rg = a[31:24];
        if (rg == 8'hF2 || (rg == 8'hF3 && !a[23])) ei[a[9:8]] = 1'b1;
        if (rg == 8'hF6 && !a[7]) eu[a[13:8]] = 1'b1;
        if (rg == 8'hF6 && a[7]) begin
            for (int i = 0; i < UN; i++)
                if (bhit(m_ut_tag[i], m_ut_v[i], 2'd0, 1'b0, d)) eu[i] = 1'b1;
            for (int j = 0; j < IN; j++)
                if (bhit(m_it_tag[j], m_it_v[j], m_it_dat[j][5:4], m_it_dat[j][1], d)) ei[j] = 1'b1;
            if (eu != '0 && ei != '0) dual_hits++;
        end
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        #2;
        // R8: enables name exactly the entries being changed
        chk(ut_we === eu, rq, "ut_we (R8)", 64'(ut_we), 64'(eu));
        chk(it_we === ei, rq, "it_we (R8)", 64'(it_we), 64'(ei));
        @(posedge clk);
        for (int i = 0; i < UN; i++) if (eu[i]) begin
            m_ut_v[i] = d[8];
            m_ut_d[i] = d[9];
            if (!a[7]) m_ut_tag[i] = d & 32'hFFFF_FCFF;
        end
        for (int j = 0; j < IN; j++) if (ei[j]) begin
            if (rg == 8'hF2) begin
                m_it_tag[j] = d & 32'hFFFF_FCFF;
                m_it_v[j] = d[8];
            end else if (rg == 8'hF3) begin
                m_it_dat[j] = d;
            end else begin
                m_it_v[j] = d[8];
                m_it_d[j] = d[9];
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] k;
        for (int i = 0; i < UN; i++) begin
            m_ut_tag[i] = '0; m_ut_v[i] = 0; m_ut_d[i] = 0;
        end
        for (int j = 0; j < IN; j++) begin
            m_it_tag[j] = '0; m_it_dat[j] = '0; m_it_v[j] = 0; m_it_d[j] = 0;
        end
        repeat (3) @(posedge clk);
        // R1: reset contents, read through the combinational ports (R9)
        verify_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        verify_all("R1");

        // R4: direct unified writes to every index
        for (int i = 0; i < UN; i++) begin
            k = {22'(i * 37 + 5), 2'b11, 8'(i * 3 + 1)};
            k[8] = (i % 3) != 0;
            k[9] = i[0];
            wr(32'hF600_0000 | (32'(i) << 8) | 32'h0000_0045, k, "R4");
        end
        verify_all("R4");

        // R2: instruction tag writes; tag copies unified entry j*5
        for (int j = 0; j < IN; j++) begin
            k = m_ut_tag[j * 5] | 32'h0000_0300;
            wr(32'hF200_0000 | (32'(j) << 8) | 32'h0080_0010, k, "R2");
        end
        verify_all("R2");

        // R3: bank-1 data writes ignored, bank-0 data writes stored (size j, entry 3 shared)
        for (int j = 0; j < IN; j++)
            wr(32'hF380_0000 | (32'(j) << 8), 32'hDEAD_BEEF, "R3");
        verify_all("R3");
        for (int j = 0; j < IN; j++)
            wr(32'hF300_0000 | (32'(j) << 8), {26'(j * 11 + 3), 2'(j), 2'b00, (j == 3), 1'b0}, "R3");
        verify_all("R3");

        // R7: every other region, and strobe low
        for (int r = 0; r < 256; r++) begin
            if (r == 'hF2 || r == 'hF3 || r == 'hF6) continue;
            wr({8'(r), 24'h00_0380}, 32'hFFFF_FFFF, "R7");
        end
        verify_all("R7");
        @(negedge clk);
        wr_addr = 32'hF600_0080;
        wr_data = m_ut_tag[2] | 32'h0000_0300;
        #2;
        chk(ut_we === '0 && it_we === '0, "R7", "enables with strobe low", 64'(ut_we), 64'h0);
        @(negedge clk);
        verify_all("R7");

        // R5/R6: associative keys from each unified tag, V/D varied
        for (int i = 0; i < UN; i++) begin
            k = m_ut_tag[i];
            k[8] = (i % 4) != 1;
            k[9] = (i % 5) == 2;
            wr(32'hF600_0080 | (32'(i) << 8), k, "R5");
        end
        verify_all("R5");
        // R6: perturbed keys against instruction entries of each size
        for (int j = 0; j < IN; j++) begin
            wr(32'hF200_0000 | (32'(j) << 8), m_it_tag[j] | 32'h0000_0100, "R6");
            k = m_it_tag[j] ^ 32'h0000_0C00;
            k[9:8] = 2'b01;
            wr(32'hF600_0080, k, "R6");
            k = m_it_tag[j] ^ 32'h000F_0000;
            k[9:8] = 2'b11;
            wr(32'hF600_0080, k, "R6");
            k = m_it_tag[j] ^ 32'h0000_005A;
            k[9:8] = 2'b11;
            wr(32'hF600_0080, k, "R6");
            k = m_it_tag[j];
            k[9:8] = 2'b11;
            wr(32'hF600_0080, k, "R5");
        end
        verify_all("R6");
        chk(dual_hits > 0, "R5", "searches hitting both arrays", 64'(dual_hits), 64'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule